// File: doc/BRIEF.md
# Clock Generator Configuration Slave on SMBus

This block is the serial control port of a clock generator. It watches the SMBus clock and data lines and holds seven 8-bit registers. Their bits gate the individual clock outputs and pick an alternate source for one output. They also enable spread-spectrum modulation and set the edge rate of the 48 MHz outputs. Power-up strap values, the live multiplier-select pin and a revision code are reported in read-only bits.

A host writes with a block write to address byte 0xD2. The command code and byte count that follow the address are acknowledged and then thrown away. Data always lands in register 0 first and moves upward. A block read to address byte 0xD3 returns a byte count of 7 followed by the whole bank, lowest register first. There is no random register addressing. Both bus lines pass through a two-flop synchroniser into a system clock that runs much faster than SCL. The slave only ever pulls SDA low through an open-drain enable.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). After any other address byte it leaves SDA released, and it ignores every later byte until a new START.
- R2: Reset loads these register values, where bit 0 is the LSB: reg0 = 0x19 with bits 2:1 = the strap, reg1 = 0x47 with bit 7 = the live multiplier select, reg2 = 0x7F, reg3 = 0xC7, reg4 = 0x3F, reg5 = 0x00, reg6 = {revision nibble, 4'b0001}.
- R3: In a write, the first two bytes after the address (command, count) are acknowledged and have no effect. Data bytes then fill reg0, reg1, … in ascending order.
- R4: A STOP after any whole data byte ends the write. Registers not reached keep their values.
- R5: Only these bits are writable: reg0 bits 3, 5, 7; reg1 bits 2:0 and 6; reg2 bits 6:0; reg3 bits 7:0; reg4 bits 5:0; reg5 bits 3:0. Reg6 is not writable. Other bits keep their reset or live value when written.
- R6: Write data bytes beyond the seventh are acknowledged and discarded.
- R7: A read returns 0x07 first, then reg0 to reg6, each byte MSB first. Bytes read past reg6 come back as 0xFF.
- R8: When the host does not acknowledge a read byte (NACK), the slave releases SDA and drives nothing more until the next START.
- R9: Reg0 bits 2:1 hold the strap value seen during reset, and later strap changes are ignored. Reg1 bit 7 follows the multiplier-select input at the time of the read.
- R10: Output fields: cpu_en = {reg1[6], reg1[2:0]}, pci_en = reg2[6:0], pcif_en = reg3[2:0], pcif_gate = reg3[5:3], usb_en = reg3[6], dot_en = reg3[7], mid_en = reg4[5:0], edge_ctl = reg5[3:0], stop_ctl = reg0[3], alt_sel = reg0[5], spread_en = reg0[7]. They change only while the slave is acknowledging a data byte.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| fs_strap | input | 2 | Frequency-select strap pins |
| mult_sel | input | 1 | Live multiplier-select pin |
| rev_id | input | 4 | Revision code shown in reg6 bits 7:4 |
| stop_ctl | output | 1 | Stop-request control bit |
| alt_sel | output | 1 | Alternate-clock select for the shared output |
| spread_en | output | 1 | Spread-spectrum enable |
| cpu_en | output | 4 | Differential CPU pair enables |
| pci_en | output | 7 | PCI clock enables |
| pcif_en | output | 3 | Free-running PCI clock enables |
| pcif_gate | output | 3 | Make the free-running PCI clocks stoppable |
| usb_en | output | 1 | USB 48 MHz enable |
| dot_en | output | 1 | DOT 48 MHz enable |
| mid_en | output | 6 | 66 MHz group enables |
| edge_ctl | output | 4 | 48 MHz edge-rate controls |

## Verification
A wrong byte position or bit counter shows up on the very next acknowledge slot. A missing or extra ACK is visible within the same 9-clock byte, and every write in the bench is read back in full within one transaction. A corrupted register or mask shows on the output fields one system clock after the data-byte ACK, and in the next block read. A state machine that fails to leave a transfer shows as SDA held low during a read of a later byte or after a NACK.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int NUM_REGS = 7;
    localparam int IDXW     = $clog2(NUM_REGS + 1);
    localparam int POSW     = $clog2(NUM_REGS + 3);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } smb_state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic       stop_ctl;
        logic       alt_sel;
        logic       spread_en;
        logic [3:0] cpu_en;
        logic [6:0] pci_en;
        logic [2:0] pcif_en;
        logic [2:0] pcif_gate;
        logic       usb_en;
        logic       dot_en;
        logic [5:0] mid_en;
        logic [3:0] edge_ctl;
    } clk_cfg_t;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h19;
            1:       return 8'h47;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            5:       return 8'h00;
            default: return 8'h01;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hA8;
            1:       return 8'h47;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h3F;
            5:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync
    import clkcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/smb_xfer_ctrl.sv
module smb_xfer_ctrl
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_evt_t        evt,
    input  logic [7:0]      rd_byte,
    output logic            sda_oe,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic [IDXW-1:0] rd_ptr,
    output smb_state_t      state
);
    localparam logic [POSW-1:0] POS_LAST  = POSW'(NUM_REGS + 2);
    localparam logic [7:0]      CNT_BYTE  = 8'(NUM_REGS);
    localparam logic [IDXW-1:0] PTR_END   = IDXW'(NUM_REGS);

    logic [7:0]      sh;
    logic [3:0]      cnt;
    logic [POSW-1:0] pos;
    logic            rw;
    logic            nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            sh      <= '0;
            cnt     <= '0;
            pos     <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            rd_ptr  <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[6:0], evt.sda};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                state  <= ST_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw     <= sh[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                state  <= ST_RD_BYTE;
                                sh     <= CNT_BYTE;
                                sda_oe <= ~CNT_BYTE[7];
                                rd_ptr <= '0;
                            end else begin
                                state  <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                                pos    <= '0;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[6:0], evt.sda};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            state  <= ST_WR_ACK;
                            sda_oe <= 1'b1;
                            if (pos >= POSW'(2) && pos < POS_LAST) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= IDXW'(pos - POSW'(2));
                                wr_data <= sh;
                            end
                            if (pos < POS_LAST) pos <= pos + POSW'(1);
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            state  <= ST_WR_BYTE;
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (cnt == 4'd8) begin
                                state  <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            nack <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state  <= ST_RD_BYTE;
                                sh     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                cnt    <= '0;
                                if (rd_ptr != PTR_END) rd_ptr <= rd_ptr + IDXW'(1);
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      fs_strap,
    input  logic            mult_sel,
    input  logic [3:0]      rev_id,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [7:0]      rd_data,
    output clk_cfg_t        cfg
);
    localparam int VIEWN = 2 ** IDXW;

    logic [7:0] store [NUM_REGS];
    logic [7:0] view  [VIEWN];
    logic [1:0] fs_lat;

    always_ff @(posedge clk) begin
        if (rst) fs_lat <= fs_strap;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] WMASK = reg_wmask(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                store[i] <= reg_default(i);
            end else if (wr_en && wr_idx == IDXW'(i)) begin
                store[i] <= (store[i] & ~WMASK) | (wr_data & WMASK);
            end
        end
    end

    for (genvar i = 0; i < VIEWN; i++) begin : g_view
        if (i == 0) begin : g_b0
            assign view[i] = store[i] | {5'b0, fs_lat, 1'b0};
        end else if (i == 1) begin : g_b1
            assign view[i] = store[i] | {mult_sel, 7'b0};
        end else if (i == NUM_REGS - 1) begin : g_last
            assign view[i] = store[i] | {rev_id, 4'b0};
        end else if (i < NUM_REGS) begin : g_plain
            assign view[i] = store[i];
        end else begin : g_pad
            assign view[i] = 8'hFF;
        end
    end

    assign rd_data = view[rd_idx];

    always_comb begin
        cfg.stop_ctl  = store[0][3];
        cfg.alt_sel   = store[0][5];
        cfg.spread_en = store[0][7];
        cfg.cpu_en    = {store[1][6], store[1][2:0]};
        cfg.pci_en    = store[2][6:0];
        cfg.pcif_en   = store[3][2:0];
        cfg.pcif_gate = store[3][5:3];
        cfg.usb_en    = store[3][6];
        cfg.dot_en    = store[3][7];
        cfg.mid_en    = store[4][5:0];
        cfg.edge_ctl  = store[5][3:0];
    end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
    import clkcfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h69
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [1:0] fs_strap,
    input  logic       mult_sel,
    input  logic [3:0] rev_id,
    output logic       stop_ctl,
    output logic       alt_sel,
    output logic       spread_en,
    output logic [3:0] cpu_en,
    output logic [6:0] pci_en,
    output logic [2:0] pcif_en,
    output logic [2:0] pcif_gate,
    output logic       usb_en,
    output logic       dot_en,
    output logic [5:0] mid_en,
    output logic [3:0] edge_ctl
);
    bus_evt_t        evt;
    smb_state_t      ctl_state;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;
    logic [IDXW-1:0] rd_ptr;
    logic [7:0]      rd_byte;
    clk_cfg_t        cfg_w;

    smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smb_xfer_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_byte (rd_byte),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .state   (ctl_state)
    );

    clkcfg_regbank u_bank (
        .clk      (clk),
        .rst      (rst),
        .fs_strap (fs_strap),
        .mult_sel (mult_sel),
        .rev_id   (rev_id),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_ptr),
        .rd_data  (rd_byte),
        .cfg      (cfg_w)
    );

    assign stop_ctl  = cfg_w.stop_ctl;
    assign alt_sel   = cfg_w.alt_sel;
    assign spread_en = cfg_w.spread_en;
    assign cpu_en    = cfg_w.cpu_en;
    assign pci_en    = cfg_w.pci_en;
    assign pcif_en   = cfg_w.pcif_en;
    assign pcif_gate = cfg_w.pcif_gate;
    assign usb_en    = cfg_w.usb_en;
    assign dot_en    = cfg_w.dot_en;
    assign mid_en    = cfg_w.mid_en;
    assign edge_ctl  = cfg_w.edge_ctl;
endmodule

// File: rtl/clkcfg_smbus_checker.sv
module clkcfg_smbus_checker
    import clkcfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_oe,
    input smb_state_t ctl_state,
    input clk_cfg_t   cfg
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_in) else $error("sda drive changed with scl high"); // R11

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == ST_IDLE) |-> !sda_oe) else $error("sda driven while idle"); // R1

    AST_CFG_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> sda_oe) else $error("config changed outside data ack"); // R10

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg.cpu_en == 4'hF && cfg.pci_en == 7'h7F &&
                        cfg.spread_en == 1'b0 && cfg.edge_ctl == 4'h0 &&
                        cfg.mid_en == 6'h3F)) else $error("bad reset config"); // R2
endmodule

bind clkcfg_smbus_slave clkcfg_smbus_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .ctl_state (ctl_state),
    .cfg       (cfg_w)
);

// File: tb/clkcfg_smbus_slave_test.sv
module clkcfg_smbus_slave_test;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [1:0] fs_strap = 2'b10;
    logic       mult_sel = 1'b1;
    logic [3:0] rev_id = 4'hA;
    logic       stop_ctl, alt_sel, spread_en, usb_en, dot_en;
    logic [3:0] cpu_en, edge_ctl;
    logic [6:0] pci_en;
    logic [2:0] pcif_en, pcif_gate;
    logic [5:0] mid_en;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] st [7];
    logic [7:0] mk [7];
    logic [7:0] wbuf [12];
    logic [7:0] rbuf [12];
    logic [1:0] fs_seen = 2'b10;

    always #5 clk = ~clk;
    assign sda_bus = sda_h & ~sda_oe;

    clkcfg_smbus_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .fs_strap(fs_strap), .mult_sel(mult_sel), .rev_id(rev_id),
        .stop_ctl(stop_ctl), .alt_sel(alt_sel), .spread_en(spread_en),
        .cpu_en(cpu_en), .pci_en(pci_en), .pcif_en(pcif_en), .pcif_gate(pcif_gate),
        .usb_en(usb_en), .dot_en(dot_en), .mid_en(mid_en), .edge_ctl(edge_ctl)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; qw(); scl = 1'b1; qw();
        sda_h = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; qw(); scl = 1'b1; qw();
        sda_h = 1'b1; qw(); qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int k = 7; k >= 0; k--) begin
            sda_h = b[k]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
        sda_h = 1'b1; qw(); scl = 1'b1; qw();
        ack = sda_bus; qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic host_nack, output logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            sda_h = 1'b1; qw(); scl = 1'b1; qw();
            b[k] = sda_bus; qw(); scl = 1'b0; qw();
        end
        sda_h = host_nack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        sda_h = 1'b1;
    endtask

    function automatic logic [7:0] view(input int i);
        case (i)
            0: return st[0] | {5'b0, fs_seen, 1'b0};
            1: return st[1] | {mult_sel, 7'b0};
            6: return st[6] | {rev_id, 4'b0};
            default: return st[i];
        endcase
    endfunction

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n, input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk({req, " R1 write addr ack"}, a, 0);
        send_byte(cmd, a);   chk("R3 command ack", a, 0);
        send_byte(cnt, a);   chk("R3 count ack", a, 0);
        for (int j = 0; j < n; j++) begin
            send_byte(wbuf[j], a);
            chk(j < 7 ? {req, " data ack"} : "R6 extra byte ack", a, 0);
            if (j < 7) st[j] = (st[j] & ~mk[j]) | (wbuf[j] & mk[j]);
        end
        bus_stop();
    endtask

    task automatic do_read(input int n);
        logic a;
        bus_start();
        send_byte(8'hD3, a); chk("R1 read addr ack", a, 0);
        for (int j = 0; j < n; j++) recv_byte(j == n - 1, rbuf[j]);
        bus_stop();
    endtask

    task automatic check_bank(input string req);
        do_read(8);
        chk("R7 count byte", rbuf[0], 8'h07);
        for (int i = 0; i < 7; i++) chk(req, rbuf[i + 1], view(i));
    endtask

    task automatic check_outputs(input string req);
        chk({req, " R10 cpu_en"}, cpu_en, {st[1][6], st[1][2:0]});
        chk({req, " R10 pci_en"}, pci_en, st[2][6:0]);
        chk({req, " R10 reg3 fields"}, {dot_en, usb_en, pcif_gate, pcif_en}, st[3]);
        chk({req, " R10 mid_en"}, mid_en, st[4][5:0]);
        chk({req, " R10 edge_ctl"}, edge_ctl, st[5][3:0]);
        chk({req, " R10 reg0 fields"}, {spread_en, alt_sel, stop_ctl}, {st[0][7], st[0][5], st[0][3]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b;
        st = '{8'h19, 8'h47, 8'h7F, 8'hC7, 8'h3F, 8'h00, 8'h01};
        mk = '{8'hA8, 8'h47, 8'h7F, 8'hFF, 8'h3F, 8'h0F, 8'h00};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        fs_strap = 2'b01;   // R9: change after reset must not show
        repeat (4) @(negedge clk);
        chk("R2 sda released after reset", sda_oe, 0);
        check_outputs("R2");
        check_bank("R2 R9 reset bank");

        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 7; i++) wbuf[i] = 8'((p * 8'h5B + i * 8'h27) ^ 8'hA5);
            do_write(8'(8'hF0 + p), 8'(p), 7, "R3");
            check_outputs("R5");
            check_bank("R5 sweep readback");
        end

        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 7; i++) wbuf[i] = 8'(~(k * 8'h33 + i * 8'h11));
            do_write(8'h00, 8'h07, k, "R4");
            check_bank("R4 partial write");
        end

        for (int i = 0; i < 10; i++) wbuf[i] = 8'(i * 8'h1D + 8'h40);
        do_write(8'h12, 8'h34, 10, "R6");
        check_bank("R6 overrun discarded");

        foreach (wbuf[i]) wbuf[i] = 8'h00;
        begin
            logic [7:0] bad [4];
            bad = '{8'hD0, 8'hD4, 8'h52, 8'hE2};
            for (int m = 0; m < 4; m++) begin
                bus_start();
                send_byte(bad[m], a); chk("R1 foreign address nack", a, 1);
                send_byte(8'h00, a);  chk("R1 later byte ignored", a, 1);
                send_byte(8'h00, a);  chk("R1 later byte ignored", a, 1);
                bus_stop();
            end
        end
        check_bank("R1 bank untouched");

        mult_sel = 1'b0;
        do_read(12);
        chk("R7 count byte", rbuf[0], 8'h07);
        for (int i = 0; i < 7; i++) chk("R7 R9 ordered bank", rbuf[i + 1], view(i));
        for (int i = 8; i < 12; i++) chk("R7 past end", rbuf[i], 8'hFF);

        bus_start();
        send_byte(8'hD3, a); chk("R8 addr ack", a, 0);
        recv_byte(1'b0, b); chk("R8 count", b, 8'h07);
        recv_byte(1'b1, b); chk("R8 reg0", b, view(0));
        chk("R8 released after nack", sda_oe, 0);
        recv_byte(1'b1, b); chk("R8 no drive after nack", b, 8'hFF);
        bus_stop();
        mult_sel = 1'b1;
        check_bank("R8 R9 next read");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule